// File: doc/BRIEF.md
# SMBus Alert Responder

This block raises a shared open-drain alert line when its fault input is active, and names itself when the host polls the alert response address. The host sees the alert line fall and issues a read to the 7-bit address 0001100. Every device with an outstanding alert acknowledges that read and places its own 7-bit address on SDA. Wired-AND arbitration on SDA lets the lowest address through intact. The host then learns which device is interrupting and reads that device's status. Reading the status ends the alert if the fault has gone by then.

The block sees the bus as two sampled levels, SCL and SDA, already synchronised to its clock. It drives SDA and the alert line only as open-drain pull-down enables, where 1 means pull low. The device address is a parameter. Ordinary register access belongs to a companion protocol engine, which supplies the one-cycle status-read strobe.

A bus-tracking machine walks through the states BUS_IDLE, BUS_ADDR, BUS_DECIDE, BUS_ACK, BUS_SEND, BUS_MACK and BUS_SKIP:

- A START condition from any state enters BUS_ADDR. A STOP condition from any state enters BUS_IDLE.
- BUS_ADDR collects eight bits on rising SCL edges, then moves to BUS_DECIDE.
- On the next falling edge, BUS_DECIDE moves to BUS_ACK on a matching read while an alert is pending. Otherwise it moves to BUS_SKIP.
- BUS_ACK moves to BUS_SEND on a falling edge.
- BUS_SEND moves to BUS_MACK after the falling edge that ends the eighth bit.
- BUS_MACK moves to BUS_SKIP on a falling edge.

An alert machine walks through the states ALR_CLEAR, ALR_PENDING and ALR_ANSWERED:

- ALR_CLEAR moves to ALR_PENDING when the fault input is high.
- ALR_PENDING moves to ALR_ANSWERED when a full address byte is sent without losing arbitration.
- ALR_ANSWERED moves on a status read. It goes to ALR_CLEAR if the fault is gone, or back to ALR_PENDING if the fault is still present.

Top module: `ara_responder`

## Requirements
- R1: After reset both drive outputs are 0. When error_i is high in ALR_CLEAR, alert_drive_o is 1 from the next clock onward.
- R2: A read addressed to 7'b0001100 (R/W bit = 1) is acknowledged in ALR_PENDING. The acknowledge is sda_drive_o = 1 throughout the ninth SCL high phase.
- R3: After acknowledging, the block sends {DEV_ADDR, 1'b0} MSB first. It pulls SDA low for each 0 bit. sda_drive_o only rises while SCL is low.
- R4: A write to 7'b0001100, or a transfer to any other address (including DEV_ADDR), is never acknowledged and SDA is not driven.
- R5: In ALR_CLEAR and ALR_ANSWERED, alert response reads are ignored: no acknowledge and no data.
- R6: On each rising SCL edge of the data byte the block samples SDA. If it released SDA and reads 0, it stops driving for the rest of the byte and stays in ALR_PENDING.
- R7: A block that lost arbitration acknowledges and answers the next alert response read.
- R8: In ALR_ANSWERED, alert_drive_o stays 1 until status_rd_i pulses. It then falls if error_i is 0 at that clock. Otherwise it stays 1 and the block becomes pending again.
- R9: A status read in ALR_PENDING leaves the alert asserted.
- R10: A START condition restarts address collection even in the middle of a transfer. A STOP condition leaves SDA released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| error_i | input | 1 | Fault condition present |
| status_rd_i | input | 1 | One-cycle strobe: the host read the status |
| alert_drive_o | output | 1 | 1 pulls the shared alert line low |
| sda_drive_o | output | 1 | 1 pulls SDA low |

## Verification
Losing arbitration is the hardest case to reach, because it needs a second device driving SDA at the same time. The bench models a rival responder on the wired-AND SDA line. The rival acknowledges the alert response read, sends its own address and drops out when it loses. Its address is chosen lower or higher than DEV_ADDR in directed cases and at random in a seeded loop. The expected byte is the smaller address, and the expected alert state follows from which device won. A START issued partway through an address is also provoked deliberately.

// File: rtl/ara_pkg.sv
package ara_pkg;

    localparam logic [6:0] ARA_ADDR = 7'b0001100;

    typedef enum logic [2:0] {
        BUS_IDLE,
        BUS_ADDR,
        BUS_DECIDE,
        BUS_ACK,
        BUS_SEND,
        BUS_MACK,
        BUS_SKIP
    } bus_state_e;

    typedef enum logic [1:0] {
        ALR_CLEAR,
        ALR_PENDING,
        ALR_ANSWERED
    } alr_state_e;

endpackage

// File: rtl/ara_line_mon.sv
module ara_line_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        scl_rise_o = scl_i & ~scl_q;
        scl_fall_o = ~scl_i & scl_q;
        start_o    = scl_i & scl_q & sda_q & ~sda_i;
        stop_o     = scl_i & scl_q & ~sda_q & sda_i;
    end

endmodule

// File: rtl/ara_alert_fsm.sv
module ara_alert_fsm
    import ara_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic error_i,
    input  logic status_rd_i,
    input  logic won_i,
    output logic pending_o,
    output logic alert_o
);

    alr_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ALR_CLEAR;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ALR_CLEAR:    if (error_i) st_d = ALR_PENDING;
            ALR_PENDING:  if (won_i) st_d = ALR_ANSWERED;
            ALR_ANSWERED: if (status_rd_i) st_d = error_i ? ALR_PENDING : ALR_CLEAR;
            default:      st_d = ALR_CLEAR;
        endcase
    end

    always_comb begin
        pending_o = (st_q == ALR_PENDING);
        alert_o   = (st_q != ALR_CLEAR);
    end

endmodule

// File: rtl/ara_tx_shift.sv
module ara_tx_shift #(
    parameter int         BYTE_W   = 8,
    parameter logic [6:0] DEV_ADDR = 7'h2E
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic shift_i,
    input  logic sample_i,
    input  logic sda_i,
    output logic drive_low_o,
    output logic lost_o
);

    localparam int PAD_W = BYTE_W - 7;

    logic [BYTE_W-1:0] tx_q;
    logic              lost_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q   <= '1;
            lost_q <= 1'b0;
        end else if (load_i) begin
            tx_q   <= {DEV_ADDR, {PAD_W{1'b0}}};
            lost_q <= 1'b0;
        end else begin
            if (sample_i && tx_q[BYTE_W-1] && !sda_i) lost_q <= 1'b1;
            if (shift_i) tx_q <= {tx_q[BYTE_W-2:0], 1'b1};
        end
    end

    always_comb begin
        drive_low_o = ~lost_q & ~tx_q[BYTE_W-1];
        lost_o      = lost_q;
    end

endmodule

// File: rtl/ara_responder.sv
module ara_responder
    import ara_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2E
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic error_i,
    input  logic status_rd_i,
    output logic alert_drive_o,
    output logic sda_drive_o
);

    localparam int                BYTE_W   = 8;
    localparam int                CNT_W    = $clog2(BYTE_W + 1);
    localparam logic [BYTE_W-1:0] ARA_READ = {ARA_ADDR, 1'b1};

    generate
        if (DEV_ADDR == ARA_ADDR) begin : g_bad_addr
            $error("device address collides with the alert response address");
        end
    endgenerate

    logic scl_rise, scl_fall, start_det, stop_det;
    logic pending, won, tx_drv, tx_lost;
    logic tx_load, tx_shift, tx_sample;

    bus_state_e        st_q, st_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] rx_q;

    ara_line_mon u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall),
        .start_o   (start_det),
        .stop_o    (stop_det)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= BUS_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (start_det) begin
            st_d = BUS_ADDR;
        end else if (stop_det) begin
            st_d = BUS_IDLE;
        end else begin
            unique case (st_q)
                BUS_IDLE:   st_d = BUS_IDLE;
                BUS_ADDR:   if (scl_rise && cnt_q == CNT_W'(BYTE_W - 1)) st_d = BUS_DECIDE;
                BUS_DECIDE: if (scl_fall) st_d = (rx_q == ARA_READ && pending) ? BUS_ACK : BUS_SKIP;
                BUS_ACK:    if (scl_fall) st_d = BUS_SEND;
                BUS_SEND:   if (scl_fall && cnt_q == CNT_W'(BYTE_W)) st_d = BUS_MACK;
                BUS_MACK:   if (scl_fall) st_d = BUS_SKIP;
                BUS_SKIP:   st_d = BUS_SKIP;
                default:    st_d = BUS_IDLE;
            endcase
        end
    end

    // bit counter and address shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rx_q  <= '0;
        end else if (start_det) begin
            cnt_q <= '0;
        end else if (st_q == BUS_ADDR && scl_rise) begin
            rx_q  <= {rx_q[BYTE_W-2:0], sda_i};
            cnt_q <= cnt_q + 1'b1;
        end else if (st_q == BUS_ACK && scl_fall) begin
            cnt_q <= '0;
        end else if (st_q == BUS_SEND && scl_rise) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        tx_load   = (st_q == BUS_ACK)  && scl_fall && !start_det && !stop_det;
        tx_shift  = (st_q == BUS_SEND) && scl_fall;
        tx_sample = (st_q == BUS_SEND) && scl_rise;
        won       = (st_q == BUS_SEND) && scl_fall && !start_det && !stop_det
                    && cnt_q == CNT_W'(BYTE_W) && !tx_lost;
    end

    ara_tx_shift #(
        .BYTE_W  (BYTE_W),
        .DEV_ADDR(DEV_ADDR)
    ) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tx_load),
        .shift_i    (tx_shift),
        .sample_i   (tx_sample),
        .sda_i      (sda_i),
        .drive_low_o(tx_drv),
        .lost_o     (tx_lost)
    );

    ara_alert_fsm u_alert (
        .clk        (clk),
        .rst_n      (rst_n),
        .error_i    (error_i),
        .status_rd_i(status_rd_i),
        .won_i      (won),
        .pending_o  (pending),
        .alert_o    (alert_drive_o)
    );

    // outputs
    always_comb begin
        sda_drive_o = (st_q == BUS_ACK) | ((st_q == BUS_SEND) & tx_drv);
    end

endmodule

// File: rtl/ara_responder_chk.sv
module ara_responder_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic error_i,
    input logic status_rd_i,
    input logic alert_drive_o,
    input logic sda_drive_o
);

    AST_ALERT_ON_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        (error_i && !alert_drive_o) |=> alert_drive_o); // R1

    AST_DRIVE_STARTS_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_o) |-> !scl_i); // R3

    AST_NO_DRIVE_WITHOUT_ALERT: assert property (@(posedge clk) disable iff (!rst_n)
        sda_drive_o |-> alert_drive_o); // R5

    AST_RELEASE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alert_drive_o) |-> ($past(status_rd_i) && !$past(error_i))); // R8

endmodule

bind ara_responder ara_responder_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl_i),
    .error_i      (error_i),
    .status_rd_i  (status_rd_i),
    .alert_drive_o(alert_drive_o),
    .sda_drive_o  (sda_drive_o)
);

// File: tb/tb_ara_responder.sv
`timescale 1ns/1ps
module tb_ara_responder;

    localparam logic [6:0] DEV = 7'h2E;
    localparam logic [6:0] ARA = 7'b0001100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic rival_drv = 1'b0;
    logic error_in = 1'b0;
    logic status_rd = 1'b0;
    logic alert_drive, sda_drive;
    logic sda_line;

    int checks = 0;
    int errors = 0;
    int exp_alr = 0; // 0 clear, 1 pending, 2 answered

    always #2 clk = ~clk;

    assign sda_line = m_sda & ~sda_drive & ~rival_drv;

    ara_responder #(.DEV_ADDR(DEV)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl),
        .sda_i        (sda_line),
        .error_i      (error_in),
        .status_rd_i  (status_rd),
        .alert_drive_o(alert_drive),
        .sda_drive_o  (sda_drive)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input bit dut_on, input bit ron, input logic [6:0] r);
        logic [7:0] b;
        b = 8'hFF;
        if (dut_on) b = {DEV, 1'b0};
        if (ron && {r, 1'b0} < b) b = {r, 1'b0};
        return b;
    endfunction

    task automatic do_start();
        m_sda = 1'b1; tick(4);
        scl = 1'b1; tick(4);
        m_sda = 1'b0; tick(4);
        scl = 1'b0; tick(4);
    endtask

    task automatic do_stop();
        m_sda = 1'b0; tick(4);
        scl = 1'b1; tick(4);
        m_sda = 1'b1; tick(4);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; tick(4);
        scl = 1'b1; tick(4);
        scl = 1'b0;
    endtask

    task automatic xfer(input logic [6:0] a, input logic rw, input bit ron, input logic [6:0] ra,
                        output logic ackb, output logic [7:0] db);
        bit   r_on;
        bit   r_lost;
        logic [7:0] rb;
        r_on   = ron && a == ARA && rw;
        r_lost = 1'b0;
        rb     = {ra, 1'b0};
        db     = 8'hFF;
        do_start();
        for (int i = 6; i >= 0; i--) send_bit(a[i]);
        send_bit(rw);
        m_sda = 1'b1; rival_drv = r_on; tick(4);
        scl = 1'b1; tick(2);
        ackb = sda_line; tick(2);
        scl = 1'b0;
        if (!ackb && rw) begin
            for (int i = 7; i >= 0; i--) begin
                m_sda = 1'b1;
                rival_drv = r_on && !r_lost && !rb[i];
                tick(4);
                scl = 1'b1; tick(2);
                db[i] = sda_line;
                if (r_on && !r_lost && rb[i] && !sda_line) r_lost = 1'b1;
                tick(2);
                scl = 1'b0;
            end
            rival_drv = 1'b0;
            send_bit(1'b1);
        end
        rival_drv = 1'b0;
        do_stop();
    endtask

    task automatic set_err(input logic v);
        error_in = v;
        tick(2);
        if (v && exp_alr == 0) exp_alr = 1;
    endtask

    task automatic status_read();
        status_rd = 1'b1; tick(1);
        status_rd = 1'b0;
        if (exp_alr == 2) exp_alr = error_in ? 1 : 0;
        tick(2);
    endtask

    task automatic check_alert(input string tag);
        chk(alert_drive == (exp_alr != 0), tag, alert_drive, exp_alr != 0);
    endtask

    task automatic ara_check(input bit ron, input logic [6:0] ra, input string tag);
        logic ackb;
        logic [7:0] db;
        bit dut_on;
        logic [7:0] eb;
        dut_on = (exp_alr == 1);
        eb = exp_byte(dut_on, ron, ra);
        xfer(ARA, 1'b1, ron, ra, ackb, db);
        chk(ackb == !(dut_on || ron), {tag, " ack"}, ackb, !(dut_on || ron));
        if (dut_on || ron) chk(db == eb, {tag, " byte"}, db, eb);
        if (dut_on && (!ron || DEV < ra)) exp_alr = 2;
        chk(sda_drive == 1'b0, "R10 released after stop", sda_drive, 0);
        check_alert({tag, " alert"});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic ackb;
        logic [7:0] db;
        void'($urandom(32'd1234));
        tick(5);
        rst_n = 1'b1;
        tick(2);
        chk(alert_drive == 1'b0 && sda_drive == 1'b0, "R1 reset state", {alert_drive, sda_drive}, 0);

        // R5: ignored while clear
        ara_check(1'b0, 7'h00, "R5 clear");

        // R1: error raises alert
        set_err(1'b1);
        check_alert("R1 error raises alert");

        // R9: status read while pending
        status_read();
        check_alert("R9 read while pending");

        // R4: write to ARA, read to own address
        xfer(ARA, 1'b0, 1'b0, 7'h00, ackb, db);
        chk(ackb == 1'b1, "R4 write to ara", ackb, 1);
        xfer(DEV, 1'b1, 1'b0, 7'h00, ackb, db);
        chk(ackb == 1'b1, "R4 own address", ackb, 1);
        check_alert("R4 alert kept");

        // R10: START cuts an address short
        do_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        ara_check(1'b0, 7'h00, "R10 R2 R3 after restart");

        // R5: answered state ignores ARA
        ara_check(1'b0, 7'h00, "R5 answered");

        // R8: read with error present keeps alert
        status_read();
        check_alert("R8 read with error");

        // R6: rival lower wins, R7: answer next time
        ara_check(1'b1, 7'h05, "R6 lose");
        chk(exp_alr == 1, "R6 still pending", exp_alr, 1);
        ara_check(1'b0, 7'h00, "R7 retry");

        // R8: read with error gone
        set_err(1'b0);
        check_alert("R8 before read");
        status_read();
        check_alert("R8 cleared");

        // R6: rival higher loses to block
        set_err(1'b1);
        ara_check(1'b1, 7'h70, "R6 win");

        // random mix
        for (int it = 0; it < 60; it++) begin
            int op;
            logic [6:0] r;
            op = $urandom % 5;
            r  = 7'($urandom % 128);
            if (r == ARA || r == DEV) r = r ^ 7'h40;
            case (op)
                0: begin set_err(1'($urandom % 2)); check_alert("R1 random error"); end
                1: begin status_read(); check_alert("R8 random read"); end
                2: ara_check(1'($urandom % 2), r, "R6 random ara");
                3: ara_check(1'b0, r, "R2 random ara");
                default: begin
                    xfer(r, 1'($urandom % 2), 1'b0, 7'h00, ackb, db);
                    chk(ackb == 1'b1, "R4 random address", ackb, 1);
                    check_alert("R4 random alert");
                end
            endcase
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule